// File: doc/BRIEF.md
# UTOPIA Transmit Cell Receiver (PHY side)

This block sits on the PHY side of a UTOPIA Level 2 transmit bus. An ATM-layer master drives the bus with an active-low write enable, a start-of-cell marker, a 5-bit PHY address, a 16-bit data bus and an odd-parity bit. The block answers address polls with a cell-available flag. It accepts cell words only when it has been selected, checks parity on every accepted word, frames the words into cells and stores them in a small cell FIFO. The reader runs on the same clock. It sees a cell-present flag and pops words one at a time with a read enable.

Bus width, cell length, single- or multi-PHY operation, the block's own PHY address and the policy for errored cells are all runtime configuration inputs. These inputs are expected to change only while the bus is idle and the FIFO is empty. A cell becomes visible to the reader only after its last word has been written. A cell that is dropped, for any reason, therefore leaves nothing behind. The tri-stated cell-available pin is modelled as a value plus an output-enable flag.

Top module: `utx_phy_tx`

## Requirements
- R1: With `cfg_multi_phy`=1, `utx_clav_oe` is 1 in exactly the cycle after a clock edge that sampled `utx_en_n`=1 and `utx_addr`=`cfg_phy_addr`, and 0 otherwise. While `utx_clav_oe` is 0, `utx_clav` is 0. With `cfg_multi_phy`=0, `utx_clav_oe` is 1 from the first edge after reset onward.
- R2: When driven, `utx_clav` is 1 exactly when the committed cells plus any cell still being written number fewer than `NUM_CELLS` (default 4).
- R3: In multi-PHY mode, words are accepted only when the address sampled in the last `utx_en_n`=1 cycle equalled `cfg_phy_addr`. Words sent after any other address is selected have no effect.
- R4: A word accepted with `utx_soc`=1 opens a cell. Accepted words with `utx_soc`=0 outside a cell are ignored. A cell closes on its `cfg_cell_words`-th word (legal range 2..`MAX_WORDS`).
- R5: With `cfg_wide`=1, all 16 data bits are stored. With `cfg_wide`=0, only `utx_data[7:0]` is stored and the stored upper byte reads as 0.
- R6: A word has good parity when the XOR of its active data bits (16 or 8) and `utx_prty` is 1. In 8-bit mode, `utx_data[15:8]` plays no part in the check.
- R7: With `cfg_keep_err`=0, a cell that has any word with bad parity is discarded. With `cfg_keep_err`=1, such a cell is stored like a good one.
- R8: A `utx_soc` word arriving inside a cell drops the partial cell and starts a new one at that word. The dropped runt leaves no words in the FIFO.
- R9: `cell_present` is 1 while at least one committed cell is held, from the cycle after its last word was accepted. Each `rd_en` cycle pops one word in write order, with `rd_sop`=1 on the first word of a cell. `rd_en` with no cell present has no effect.
- R10: A `utx_soc` word arriving while `NUM_CELLS` cells are committed is ignored, along with the rest of that cell.
- R11: During reset `utx_clav`, `utx_clav_oe` and `cell_present` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and reader clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 1 = 16-bit data bus, 0 = 8-bit |
| cfg_multi_phy | input | 1 | 1 = address polling and selection, 0 = single PHY |
| cfg_phy_addr | input | 5 | This PHY's bus address |
| cfg_keep_err | input | 1 | 1 = keep cells with parity errors, 0 = discard them |
| cfg_cell_words | input | LEN_W (7) | Bus words per cell |
| utx_en_n | input | 1 | Active-low write enable |
| utx_soc | input | 1 | Start-of-cell marker |
| utx_addr | input | 5 | PHY address for polling and selection |
| utx_data | input | 16 | Cell data word |
| utx_prty | input | 1 | Odd parity over the active data bits |
| utx_clav | output | 1 | Cell-available flag |
| utx_clav_oe | output | 1 | Drive enable for the cell-available pin |
| rd_en | input | 1 | Pop one word |
| cell_present | output | 1 | At least one complete cell is stored |
| rd_data | output | 16 | Word at the head of the FIFO |
| rd_sop | output | 1 | Head word is the first of its cell |

## Verification
The embedded assertions check on every cycle that the cell-available flag is driven only after a matching poll and is silent while not driven. They also check that the FIFO never commits past its capacity, that a commit only closes an open cell, that a start marker always restarts framing, and that a pop on an empty FIFO moves no pointer. Cell contents, the byte masking of the narrow mode, the parity policy, runt and overflow discards, and word order through a full FIFO are shown only by the bench's scenarios. The bench sweeps both widths over a range of cell lengths and compares every word it reads against a pattern computed from the cell's index.

// File: rtl/utx_pkg.sv
package utx_pkg;

   localparam int UTX_DATA_W = 16;
   localparam int UTX_ADDR_W = 5;

   typedef enum logic {
      FR_IDLE = 1'b0,
      FR_BODY = 1'b1
   } frame_state_e;

   // Odd parity: data bits in use plus the parity bit hold an odd number of ones
   function automatic logic parity_good(logic [UTX_DATA_W-1:0] d, logic p, logic wide);
      logic x;
      x = wide ? ^d : ^d[7:0];
      return x ^ p;
   endfunction

   function automatic logic [UTX_DATA_W-1:0] lane_data(logic [UTX_DATA_W-1:0] d, logic wide);
      return wide ? d : {8'h00, d[7:0]};
   endfunction

endpackage

// File: rtl/utx_bus_select.sv
module utx_bus_select #(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_multi,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              en_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              space_ok,
   output logic              sel,
   output logic              clav,
   output logic              clav_oe
);

   logic sel_q;
   logic poll_hit;
   logic oe_d;

   assign poll_hit = en_n && (addr == cfg_addr);
   assign oe_d     = cfg_multi ? poll_hit : 1'b1;

   // Selection is taken from the last address seen with the enable idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b0;
      end else if (en_n) begin
         sel_q <= (addr == cfg_addr);
      end
   end

   assign sel = !cfg_multi || sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clav_oe <= 1'b0;
         clav    <= 1'b0;
      end else begin
         clav_oe <= oe_d;
         clav    <= oe_d && space_ok;
      end
   end

   // R1
   clav_oe_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_multi && $past(cfg_multi) && clav_oe)
         |-> ($past(en_n) && ($past(addr) == $past(cfg_addr))));

   // R1
   clav_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clav_oe |-> !clav);

endmodule

// File: rtl/utx_framer.sv
module utx_framer
   import utx_pkg::*;
#(
   parameter int MAX_WORDS = 64,
   localparam int WIDX  = $clog2(MAX_WORDS),
   localparam int LEN_W = $clog2(MAX_WORDS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wide,
   input  logic                  cfg_keep,
   input  logic [LEN_W-1:0]      cfg_len,
   input  logic                  word_valid,
   input  logic                  soc,
   input  logic [UTX_DATA_W-1:0] data,
   input  logic                  prty,
   input  logic                  slot_free,
   output logic                  wr_en,
   output logic [WIDX-1:0]       wr_idx,
   output logic [UTX_DATA_W-1:0] wr_data,
   output logic                  commit,
   output logic                  busy
);

   frame_state_e      state_q;
   logic [WIDX-1:0]   wcnt_q;
   logic              err_q;
   logic              perr;
   logic              last_word;
   logic [LEN_W-1:0]  last_idx;

   assign perr      = !parity_good(data, prty, cfg_wide);
   assign last_idx  = cfg_len - LEN_W'(1);
   assign last_word = (state_q == FR_BODY) && !soc && (LEN_W'(wcnt_q) == last_idx);
   assign busy      = (state_q == FR_BODY);
   assign wr_data   = lane_data(data, cfg_wide);
   assign wr_idx    = soc ? '0 : wcnt_q;

   always_comb begin
      wr_en  = 1'b0;
      commit = 1'b0;
      if (word_valid) begin
         if (soc) begin
            wr_en = slot_free;
         end else if (state_q == FR_BODY) begin
            wr_en  = 1'b1;
            commit = last_word && (cfg_keep || !(err_q || perr));
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FR_IDLE;
         wcnt_q  <= '0;
         err_q   <= 1'b0;
      end else if (word_valid) begin
         if (soc) begin
            state_q <= slot_free ? FR_BODY : FR_IDLE;
            wcnt_q  <= WIDX'(1);
            err_q   <= perr;
         end else if (state_q == FR_BODY) begin
            if (last_word) begin
               state_q <= FR_IDLE;
               wcnt_q  <= '0;
               err_q   <= 1'b0;
            end else begin
               wcnt_q <= wcnt_q + WIDX'(1);
               err_q  <= err_q || perr;
            end
         end
      end
   end

   // R4
   commit_in_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (busy && !soc && word_valid));

   // R8
   soc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && soc && slot_free) |=> (busy && (wcnt_q == WIDX'(1))));

   // R4
   idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && !soc && !busy) |-> !wr_en);

endmodule

// File: rtl/utx_cell_fifo.sv
module utx_cell_fifo
   import utx_pkg::*;
#(
   parameter int NUM_CELLS = 4,
   parameter int MAX_WORDS = 64,
   localparam int SLOT_W = $clog2(NUM_CELLS),
   localparam int CNT_W  = $clog2(NUM_CELLS + 1),
   localparam int WIDX   = $clog2(MAX_WORDS),
   localparam int LEN_W  = $clog2(MAX_WORDS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [LEN_W-1:0]      cfg_len,
   input  logic                  wr_en,
   input  logic [WIDX-1:0]       wr_idx,
   input  logic [UTX_DATA_W-1:0] wr_data,
   input  logic                  commit,
   input  logic                  rd_en,
   output logic                  full,
   output logic [CNT_W-1:0]      count,
   output logic                  cell_present,
   output logic [UTX_DATA_W-1:0] rd_data,
   output logic                  rd_sop
);

   logic [SLOT_W-1:0]     wr_slot_q;
   logic [SLOT_W-1:0]     rd_slot_q;
   logic [WIDX-1:0]       rd_idx_q;
   logic [CNT_W-1:0]      count_q;
   logic                  pop;
   logic                  release_cell;
   logic [LEN_W-1:0]      last_idx;
   logic [UTX_DATA_W-1:0] slot_rd [NUM_CELLS];

   // One storage bank per cell slot
   for (genvar s = 0; s < NUM_CELLS; s++) begin : g_slot
      logic [UTX_DATA_W-1:0] bank [MAX_WORDS];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_slot_q == SLOT_W'(s))) begin
            bank[wr_idx] <= wr_data;
         end
      end
      assign slot_rd[s] = bank[rd_idx_q];
   end

   assign last_idx     = cfg_len - LEN_W'(1);
   assign cell_present = (count_q != '0);
   assign full         = (count_q == CNT_W'(NUM_CELLS));
   assign count        = count_q;
   assign pop          = rd_en && cell_present;
   assign release_cell = pop && (LEN_W'(rd_idx_q) == last_idx);
   assign rd_data      = slot_rd[rd_slot_q];
   assign rd_sop       = cell_present && (rd_idx_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_slot_q <= '0;
         rd_slot_q <= '0;
         rd_idx_q  <= '0;
         count_q   <= '0;
      end else begin
         if (commit) begin
            wr_slot_q <= wr_slot_q + SLOT_W'(1);
         end
         if (pop) begin
            if (release_cell) begin
               rd_idx_q  <= '0;
               rd_slot_q <= rd_slot_q + SLOT_W'(1);
            end else begin
               rd_idx_q <= rd_idx_q + WIDX'(1);
            end
         end
         count_q <= count_q + CNT_W'(commit) - CNT_W'(release_cell);
      end
   end

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(NUM_CELLS));

   // R10
   full_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !full);

   // R9
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !cell_present) |=> ($stable(rd_idx_q) && $stable(rd_slot_q)));

endmodule

// File: rtl/utx_phy_tx.sv
module utx_phy_tx
   import utx_pkg::*;
#(
   parameter int NUM_CELLS = 4,
   parameter int MAX_WORDS = 64,
   localparam int LEN_W = $clog2(MAX_WORDS + 1),
   localparam int WIDX  = $clog2(MAX_WORDS),
   localparam int CNT_W = $clog2(NUM_CELLS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wide,
   input  logic                  cfg_multi_phy,
   input  logic [UTX_ADDR_W-1:0] cfg_phy_addr,
   input  logic                  cfg_keep_err,
   input  logic [LEN_W-1:0]      cfg_cell_words,
   input  logic                  utx_en_n,
   input  logic                  utx_soc,
   input  logic [UTX_ADDR_W-1:0] utx_addr,
   input  logic [UTX_DATA_W-1:0] utx_data,
   input  logic                  utx_prty,
   output logic                  utx_clav,
   output logic                  utx_clav_oe,
   input  logic                  rd_en,
   output logic                  cell_present,
   output logic [UTX_DATA_W-1:0] rd_data,
   output logic                  rd_sop
);

   if (NUM_CELLS < 2 || (NUM_CELLS & (NUM_CELLS - 1)) != 0) begin : g_bad_cells
      $error("NUM_CELLS must be a power of two of at least 2");
   end
   if (MAX_WORDS < 2 || (MAX_WORDS & (MAX_WORDS - 1)) != 0) begin : g_bad_words
      $error("MAX_WORDS must be a power of two of at least 2");
   end

   logic                  sel;
   logic                  accept;
   logic                  space_ok;
   logic                  full;
   logic                  busy;
   logic [CNT_W-1:0]      count;
   logic [CNT_W-1:0]      used;
   logic                  wr_en;
   logic [WIDX-1:0]       wr_idx;
   logic [UTX_DATA_W-1:0] wr_data;
   logic                  commit;

   assign accept   = !utx_en_n && sel;
   assign used     = count + CNT_W'(busy);
   assign space_ok = (used < CNT_W'(NUM_CELLS));

   utx_bus_select #(
      .ADDR_W (UTX_ADDR_W)
   ) i_select (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_multi (cfg_multi_phy),
      .cfg_addr  (cfg_phy_addr),
      .en_n      (utx_en_n),
      .addr      (utx_addr),
      .space_ok  (space_ok),
      .sel       (sel),
      .clav      (utx_clav),
      .clav_oe   (utx_clav_oe)
   );

   utx_framer #(
      .MAX_WORDS (MAX_WORDS)
   ) i_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wide   (cfg_wide),
      .cfg_keep   (cfg_keep_err),
      .cfg_len    (cfg_cell_words),
      .word_valid (accept),
      .soc        (utx_soc),
      .data       (utx_data),
      .prty       (utx_prty),
      .slot_free  (!full),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .commit     (commit),
      .busy       (busy)
   );

   utx_cell_fifo #(
      .NUM_CELLS (NUM_CELLS),
      .MAX_WORDS (MAX_WORDS)
   ) i_fifo (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_len      (cfg_cell_words),
      .wr_en        (wr_en),
      .wr_idx       (wr_idx),
      .wr_data      (wr_data),
      .commit       (commit),
      .rd_en        (rd_en),
      .full         (full),
      .count        (count),
      .cell_present (cell_present),
      .rd_data      (rd_data),
      .rd_sop       (rd_sop)
   );

   // R3
   unselected_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (!utx_en_n && sel));

   // R2
   clav_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (utx_clav && !$past(busy) && !$past(commit)) |-> (count < CNT_W'(NUM_CELLS)));

endmodule

// File: tb/test_utx_phy_tx.sv
module test_utx_phy_tx;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wide, cfg_multi_phy, cfg_keep_err;
   logic [4:0]  cfg_phy_addr;
   logic [6:0]  cfg_cell_words;
   logic        utx_en_n, utx_soc, utx_prty;
   logic [4:0]  utx_addr;
   logic [15:0] utx_data;
   logic        utx_clav, utx_clav_oe;
   logic        rd_en, cell_present, rd_sop;
   logic [15:0] rd_data;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   utx_phy_tx i_utx_phy_tx (
      .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_multi_phy(cfg_multi_phy),
      .cfg_phy_addr(cfg_phy_addr), .cfg_keep_err(cfg_keep_err), .cfg_cell_words(cfg_cell_words),
      .utx_en_n(utx_en_n), .utx_soc(utx_soc), .utx_addr(utx_addr), .utx_data(utx_data),
      .utx_prty(utx_prty), .utx_clav(utx_clav), .utx_clav_oe(utx_clav_oe), .rd_en(rd_en),
      .cell_present(cell_present), .rd_data(rd_data), .rd_sop(rd_sop)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] pattern(int base, int i);
      return 16'(base * 37 + i * 4099 + 16'h1234);
   endfunction

   function automatic logic [15:0] stored(logic [15:0] w);
      return cfg_wide ? w : {8'h00, w[7:0]};
   endfunction

   function automatic logic good_par(logic [15:0] w);
      return cfg_wide ? ~^w : ~^w[7:0];
   endfunction

   task automatic send_cell(int base, int n, int bad_at = -1, bit do_sel = 1'b0,
                            logic [4:0] sel_addr = 5'd0);
      if (do_sel) begin
         @(negedge clk);
         utx_en_n = 1'b1; utx_soc = 1'b0; utx_addr = sel_addr;
      end
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         utx_en_n = 1'b0;
         utx_soc  = (i == 0);
         utx_data = pattern(base, i);
         utx_prty = good_par(pattern(base, i)) ^ (i == bad_at);
      end
      @(negedge clk);
      utx_en_n = 1'b1;
      utx_soc  = 1'b0;
   endtask

   task automatic send_stray(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         utx_en_n = 1'b0; utx_soc = 1'b0;
         utx_data = pattern(7, i); utx_prty = good_par(pattern(7, i));
      end
      @(negedge clk);
      utx_en_n = 1'b1;
   endtask

   task automatic read_cell(string req, int base, int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (i == 0) chk({req, " cell_present"}, cell_present, 1'b1);
         chk({req, " rd_data"}, rd_data, stored(pattern(base, i)));
         chk({req, " rd_sop"}, rd_sop, (i == 0));
         rd_en = 1'b1;
      end
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic expect_empty(string req);
      @(negedge clk);
      chk({req, " cell_present"}, cell_present, 1'b0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_wide = 1'b1; cfg_multi_phy = 1'b0; cfg_keep_err = 1'b0;
      cfg_phy_addr = 5'd5; cfg_cell_words = 7'd6;
      utx_en_n = 1'b1; utx_soc = 1'b0; utx_addr = 5'd0; utx_data = '0; utx_prty = 1'b0;
      rd_en = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11 reset values
      chk("R11 clav", utx_clav, 1'b0);
      chk("R11 clav_oe", utx_clav_oe, 1'b0);
      chk("R11 cell_present", cell_present, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 single-PHY drives always; R2 empty FIFO has room
      chk("R1 single oe", utx_clav_oe, 1'b1);
      chk("R2 empty clav", utx_clav, 1'b1);

      // R4 R5 R9 sweep over width and cell length
      for (int w = 0; w < 2; w++) begin
         cfg_wide = w[0];
         for (int len = 2; len <= 9; len++) begin
            cfg_cell_words = 7'(len);
            send_cell(len + 16 * w, len);
            read_cell(w ? "R5 wide R4" : "R5 narrow R4", len + 16 * w, len);
            expect_empty("R9 drained");
         end
      end

      // R7 R6 parity policy, 16-bit
      cfg_wide = 1'b1; cfg_cell_words = 7'd6;
      send_cell(40, 6, 3);
      expect_empty("R7 discard bad parity");
      cfg_keep_err = 1'b1;
      send_cell(41, 6, 0);
      read_cell("R7 keep bad parity", 41, 6);
      cfg_keep_err = 1'b0;
      // R6 narrow: upper byte ignored, error on last word detected
      cfg_wide = 1'b0;
      send_cell(42, 6, 5);
      expect_empty("R6 narrow bad parity");
      send_cell(43, 6);
      read_cell("R6 narrow upper byte ignored", 43, 6);
      cfg_wide = 1'b1;

      // R4 stray words outside a cell
      send_stray(5);
      expect_empty("R4 stray words");
      send_cell(50, 6);
      read_cell("R4 after strays", 50, 6);

      // R8 runt aborted by new start
      send_cell(90, 3);
      send_cell(91, 6);
      read_cell("R8 restart", 91, 6);
      expect_empty("R8 runt left nothing");

      // R2 R10 fill the FIFO
      cfg_cell_words = 7'd4;
      for (int c = 0; c < 4; c++) begin
         send_cell(100 + c, 4);
         @(negedge clk);
         chk("R2 clav while filling", utx_clav, (c < 3));
      end
      send_cell(200, 4);
      for (int c = 0; c < 4; c++) read_cell("R10 R9 order", 100 + c, 4);
      expect_empty("R10 overflow dropped");
      @(negedge clk);
      chk("R2 clav after drain", utx_clav, 1'b1);

      // R2 a cell in progress reserves the last slot
      for (int c = 0; c < 3; c++) send_cell(300 + c * 2, 4);
      send_cell(299, 2);
      @(negedge clk);
      @(negedge clk);
      chk("R2 in-progress slot", utx_clav, 1'b0);
      send_cell(301, 4);
      for (int c = 0; c < 3; c++) read_cell("R2 R9 in-progress order", 300 + c * 2, 4);
      read_cell("R8 R9 abort final", 301, 4);

      // R9 pop on empty has no effect
      @(negedge clk);
      rd_en = 1'b1;
      repeat (3) @(negedge clk);
      rd_en = 1'b0;
      send_cell(400, 4);
      read_cell("R9 empty pop ignored", 400, 4);

      // R1 R3 multi-PHY polling and selection
      cfg_multi_phy = 1'b1;
      @(negedge clk);
      utx_en_n = 1'b1; utx_addr = 5'd5;
      @(negedge clk);
      chk("R1 poll own oe", utx_clav_oe, 1'b1);
      chk("R1 poll own clav", utx_clav, 1'b1);
      utx_addr = 5'd7;
      @(negedge clk);
      chk("R1 poll other oe", utx_clav_oe, 1'b0);
      chk("R1 poll other clav", utx_clav, 1'b0);
      utx_en_n = 1'b0; utx_addr = 5'd5;
      @(negedge clk);
      chk("R1 enable low oe", utx_clav_oe, 1'b0);
      utx_en_n = 1'b1; utx_addr = 5'd0;
      send_cell(500, 4, -1, 1'b1, 5'd7);
      expect_empty("R3 other PHY selected");
      send_cell(501, 4, -1, 1'b1, 5'd5);
      read_cell("R3 own PHY selected", 501, 4);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule